// File: doc/BRIEF.md
# Serial Configuration ROM Read Responder

This block answers a host that bit-bangs a three-wire serial ROM protocol through a register: on every write strobe the host presents a chip-select level, a serial-clock level and one data bit. The responder decodes a read command from that stream and returns the addressed 16-bit word one bit at a time on a single data-out line, which the host samples after each clocked write.

The ROM is 64 words of 16 bits (128 bytes). Its image is produced from parameters and a station-address input: a format version, a chip count, the six address bytes, a little-endian pointer to an information leaf and a media count inside that leaf. All other bytes read as zero. A transfer is 25 counted bits: three opcode bits, six address bits and sixteen data bits. After the last one the responder re-arms by itself, so a host can read word after word without dropping chip select.

Top module: `srom_read_responder`

## Requirements
- R1: While reset is asserted and after it is released, `doutOut` is 0 and no transfer is in progress.
- R2: A write whose chip select is 1 after a write whose chip select was 0 (or after reset) abandons any partial transfer; the bit in that same write is then treated as the first bit of a new one.
- R3: Only writes with `sclkIn` = 1 count a bit, and `dinIn` is taken from that write; writes with `sclkIn` = 0 and cycles without `wrEn` change neither the bit position nor `doutOut`, except as R2 states.
- R4: Counted bits equal to 0 that arrive before the first 1 of a transfer are discarded, so every opcode begins with a 1.
- R5: The opcode is the first three counted bits, first bit most significant; the value 3'b110 selects a read.
- R6: During a read, the six address bits arrive most significant first; after each of the first five `doutOut` is 1 and after the sixth it is 0.
- R7: After each of the next sixteen bits, `doutOut` presents the next bit of the addressed word, most significant first, where the word's low byte is ROM byte 2*addr and its high byte is byte 2*addr+1.
- R8: After the 25th counted bit the responder returns to waiting for an opcode with chip select still high; a following read works with no deselect.
- R9: For any opcode other than 3'b110, `doutOut` is 0 after each of the remaining 22 bits, and the transfer still ends after 25 bits.
- R10: ROM bytes: byte 18 holds the version (1), byte 19 the chip count (1), bytes 20 to 25 the station address with `macAddr[47:40]` at byte 20, bytes 27 and 28 the leaf offset 30 in little-endian order, byte 32 the media count (2); every other byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host register write strobe, one cycle per write |
| csIn | input | 1 | Chip-select level carried by the write |
| sclkIn | input | 1 | Serial-clock level carried by the write |
| dinIn | input | 1 | Serial data bit carried by the write |
| macAddr | input | 48 | Station address placed in the ROM image, first byte in bits 47:40 |
| doutOut | output | 1 | Serial data returned to the host |

## Verification
The bench pads transfers with leading zeros, which a responder that counted them would turn into a wrong opcode and a shifted address. It drops and raises chip select halfway through an address, where a design without the edge clear would splice two transfers into one garbage word. It reads words back to back without deselect, which a design that never re-armed would answer with a stuck or zero line, and it sends an unsupported opcode, where a design that still drove address markers or data would put ones on the line. Extra writes with the serial clock low are interleaved with every bit, so a design that counted levels instead of clocked writes would run out of step.

// File: rtl/srom_resp_pkg.sv
package srom_resp_pkg;

  localparam int WORD_IDX_W = 4;

  typedef enum logic [1:0] {
    OUT_KEEP,
    OUT_ONE,
    OUT_ZERO,
    OUT_WORD
  } out_sel_e;

  typedef struct packed {
    logic                  clearAddr;
    logic                  shiftAddr;
    out_sel_e              outSel;
    logic [WORD_IDX_W-1:0] wordBit;
  } srom_strobe_t;

endpackage

// File: rtl/srom_resp_ctrl.sv
module srom_resp_ctrl
  import srom_resp_pkg::*;
#(
  parameter int OP_W = 3,
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter logic [OP_W-1:0] READ_OP = 3'b110,
  parameter int CNT_W = $clog2(OP_W + ADDR_W + WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             csIn,
  input  logic             sclkIn,
  input  logic             dinIn,
  output srom_strobe_t     strobe,
  output logic [CNT_W-1:0] bitCount
);

  localparam int DATA_START = OP_W + ADDR_W;
  localparam int TOTAL_BITS = DATA_START + WORD_W;

  logic            csLast;
  logic            started;
  logic [OP_W-1:0] opcode;

  logic            selRise, active, startedEff, inOp, inAddr, lastBit, isRead;
  logic [CNT_W-1:0] cntEff;
  logic [OP_W-1:0]  opEff;

  always_comb begin
    selRise    = wrEn & csIn & ~csLast;
    cntEff     = selRise ? '0 : bitCount;
    startedEff = selRise ? 1'b0 : started;
    opEff      = selRise ? '0 : opcode;
    active     = wrEn & sclkIn & (dinIn | startedEff);
    inOp       = int'(cntEff) < OP_W;
    inAddr     = !inOp && (int'(cntEff) < DATA_START);
    lastBit    = int'(cntEff) == TOTAL_BITS - 1;
    isRead     = opEff == READ_OP;

    strobe.clearAddr = selRise | (active & lastBit);
    strobe.shiftAddr = active & inAddr & isRead;
    strobe.wordBit   = WORD_IDX_W'(WORD_W - 1 - (int'(cntEff) - DATA_START));
    strobe.outSel    = OUT_KEEP;
    if (active && !inOp) begin
      if (!isRead)
        strobe.outSel = OUT_ZERO;
      else if (inAddr)
        strobe.outSel = (int'(cntEff) < DATA_START - 1) ? OUT_ONE : OUT_ZERO;
      else
        strobe.outSel = OUT_WORD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLast   <= 1'b0;
      started  <= 1'b0;
      opcode   <= '0;
      bitCount <= '0;
    end else if (wrEn) begin
      csLast <= csIn;
      if (selRise) begin
        started  <= 1'b0;
        opcode   <= '0;
        bitCount <= '0;
      end
      if (active) begin
        if (inOp) begin
          started <= 1'b1;
          opcode  <= {opEff[OP_W-2:0], dinIn};
        end
        if (lastBit) begin
          started  <= 1'b0;
          opcode   <= '0;
          bitCount <= '0;
        end else begin
          bitCount <= cntEff + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/srom_resp_data.sv
module srom_resp_data
  import srom_resp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int VER_OFS = 18,
  parameter int MAC_OFS = 20,
  parameter int LEAF_PTR_OFS = 27,
  parameter int LEAF_OFS = 30,
  parameter logic [7:0] VERSION = 8'd1,
  parameter logic [7:0] CHIPS = 8'd1,
  parameter logic [7:0] MEDIA_COUNT = 8'd2
) (
  input  logic         clk,
  input  logic         rstN,
  input  srom_strobe_t strobe,
  input  logic         dinIn,
  input  logic [47:0]  macAddr,
  output logic         doutOut
);

  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int MAC_BYTES = 6;
  localparam logic [15:0] LEAF_PTR = 16'(LEAF_OFS);

  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] wordVal;

  function automatic logic [7:0] byteAt(input int idx, input logic [47:0] mac);
    logic [7:0] v;
    v = 8'h00;
    if (idx == VER_OFS) v = VERSION;
    else if (idx == VER_OFS + 1) v = CHIPS;
    else if (idx >= MAC_OFS && idx < MAC_OFS + MAC_BYTES)
      v = mac[47 - 8 * (idx - MAC_OFS) -: 8];
    else if (idx == LEAF_PTR_OFS) v = LEAF_PTR[7:0];
    else if (idx == LEAF_PTR_OFS + 1) v = LEAF_PTR[15:8];
    else if (idx == LEAF_OFS + 2) v = MEDIA_COUNT;
    return v;
  endfunction

  always_comb begin
    wordVal = '0;
    for (int b = 0; b < BYTES_PER_WORD; b++)
      wordVal[8*b +: 8] = byteAt(BYTES_PER_WORD * int'(addrReg) + b, macAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      doutOut <= 1'b0;
    end else begin
      if (strobe.clearAddr) addrReg <= '0;
      else if (strobe.shiftAddr) addrReg <= {addrReg[ADDR_W-2:0], dinIn};
      case (strobe.outSel)
        OUT_ONE:  doutOut <= 1'b1;
        OUT_ZERO: doutOut <= 1'b0;
        OUT_WORD: doutOut <= wordVal[strobe.wordBit];
        default:  doutOut <= doutOut;
      endcase
    end
  end

endmodule

// File: rtl/srom_read_responder.sv
module srom_read_responder
  import srom_resp_pkg::*;
#(
  parameter int OP_W = 3,
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter logic [OP_W-1:0] READ_OP = 3'b110,
  parameter int VER_OFS = 18,
  parameter int MAC_OFS = 20,
  parameter int LEAF_PTR_OFS = 27,
  parameter int LEAF_OFS = 30,
  parameter logic [7:0] VERSION = 8'd1,
  parameter logic [7:0] CHIPS = 8'd1,
  parameter logic [7:0] MEDIA_COUNT = 8'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        csIn,
  input  logic        sclkIn,
  input  logic        dinIn,
  input  logic [47:0] macAddr,
  output logic        doutOut
);

  localparam int TOTAL_BITS = OP_W + ADDR_W + WORD_W;
  localparam int CNT_W = $clog2(TOTAL_BITS + 1);

  srom_strobe_t     strobe;
  logic [CNT_W-1:0] bitCount;

  srom_resp_ctrl #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .READ_OP(READ_OP), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .csIn(csIn),
    .sclkIn(sclkIn), .dinIn(dinIn), .strobe(strobe), .bitCount(bitCount)
  );

  srom_resp_data #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .VER_OFS(VER_OFS),
    .MAC_OFS(MAC_OFS), .LEAF_PTR_OFS(LEAF_PTR_OFS), .LEAF_OFS(LEAF_OFS),
    .VERSION(VERSION), .CHIPS(CHIPS), .MEDIA_COUNT(MEDIA_COUNT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dinIn(dinIn),
    .macAddr(macAddr), .doutOut(doutOut)
  );

endmodule

// File: rtl/srom_read_responder_chk.sv
module srom_read_responder_chk #(
  parameter int TOTAL_BITS = 25,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             csIn,
  input logic             sclkIn,
  input logic             dinIn,
  input logic             doutOut,
  input logic [CNT_W-1:0] bitCount
);

  logic csSeen;
  logic selRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csSeen <= 1'b0;
    else if (wrEn) csSeen <= csIn;
  end

  assign selRise = wrEn & csIn & ~csSeen;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (!doutOut && bitCount == '0));

  p_select_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    selRise && !(sclkIn && dinIn) |=> bitCount == '0);

  p_unclocked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && sclkIn) && !selRise |=> ($stable(doutOut) && $stable(bitCount)));

  p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !dinIn && bitCount == '0 && !selRise |=> ($stable(doutOut) && bitCount == '0));

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && sclkIn && !selRise && int'(bitCount) == TOTAL_BITS - 1 |=> bitCount == '0);

  p_count_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitCount) < TOTAL_BITS);

endmodule

bind srom_read_responder srom_read_responder_chk #(
  .TOTAL_BITS(TOTAL_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .csIn(csIn), .sclkIn(sclkIn),
  .dinIn(dinIn), .doutOut(doutOut), .bitCount(bitCount)
);

// File: tb/srom_read_responder_tb.sv
module srom_read_responder_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, csIn = 1'b0, sclkIn = 1'b0, dinIn = 1'b0;
  logic [47:0] macAddr = 48'h0a1b2c3d4e5f;
  logic doutOut;

  int checks = 0;
  int fails = 0;
  bit noisy = 0;
  bit done = 0;

  always #4 clk = ~clk;

  srom_read_responder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .csIn(csIn), .sclkIn(sclkIn),
    .dinIn(dinIn), .macAddr(macAddr), .doutOut(doutOut)
  );

  // {address, expected word} (R7, R10)
  localparam int NVEC = 8;
  localparam logic [21:0] VEC [NVEC] = '{
    {6'd9,  16'h0101}, {6'd10, 16'h1B0A}, {6'd11, 16'h3D2C}, {6'd12, 16'h5F4E},
    {6'd13, 16'h1E00}, {6'd14, 16'h0000}, {6'd16, 16'h0002}, {6'd63, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic cs, input logic sc, input logic d);
    @(negedge clk);
    csIn = cs; sclkIn = sc; dinIn = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendBit(input logic b, output logic o);
    if (noisy) begin
      doWrite(1'b1, 1'b0, ~b);
      sclkIn = 1'b1; dinIn = ~b;
      repeat (2) @(negedge clk);
    end
    doWrite(1'b1, 1'b0, b);
    doWrite(1'b1, 1'b1, b);
    o = doutOut;
  endtask

  task automatic reselect();
    doWrite(1'b0, 1'b0, 1'b0);
    doWrite(1'b1, 1'b0, 1'b0);
  endtask

  task automatic readWord(input logic [5:0] a, input logic [15:0] exp, input string tag);
    logic o;
    logic [15:0] got;
    sendBit(1'b1, o); sendBit(1'b1, o); sendBit(1'b0, o);
    for (int i = 0; i < 6; i++) begin
      sendBit(a[5-i], o);
      check({"R6 marker ", tag}, {15'd0, o}, {15'd0, (i < 5)});
    end
    for (int i = 0; i < 16; i++) begin
      sendBit(1'b0, o);
      got[15-i] = o;
    end
    check(tag, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic o;
    repeat (3) @(negedge clk);
    check("R1 dout in reset", {15'd0, doutOut}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 dout after reset", {15'd0, doutOut}, 16'h0);

    // table walk, one selection per word
    for (int v = 0; v < NVEC; v++) begin
      reselect();
      readWord(VEC[v][21:16], VEC[v][15:0], "R7 R10 R5 table word");
    end

    // R4: leading zeros discarded
    reselect();
    for (int i = 0; i < 4; i++) sendBit(1'b0, o);
    check("R4 dout unchanged by zeros", {15'd0, o}, 16'h0);
    readWord(6'd10, 16'h1B0A, "R4 read after zeros");

    // R8: back-to-back reads with chip select held
    reselect();
    readWord(6'd11, 16'h3D2C, "R8 first of pair");
    readWord(6'd12, 16'h5F4E, "R8 second of pair");
    readWord(6'd9,  16'h0101, "R8 third of run");

    // R2: reselect abandons a partial transfer
    reselect();
    sendBit(1'b1, o); sendBit(1'b1, o); sendBit(1'b0, o);
    sendBit(1'b1, o); sendBit(1'b1, o);
    reselect();
    readWord(6'd13, 16'h1E00, "R2 read after mid reselect");

    // R9: unsupported opcode keeps dout low for the rest of the transfer
    reselect();
    sendBit(1'b1, o); sendBit(1'b0, o); sendBit(1'b1, o);
    begin
      logic anyHigh;
      anyHigh = 1'b0;
      for (int i = 0; i < 22; i++) begin
        sendBit(1'b1, o);
        anyHigh = anyHigh | o;
      end
      check("R9 dout low on unsupported opcode", {15'd0, anyHigh}, 16'h0);
    end
    readWord(6'd16, 16'h0002, "R9 R8 read after unsupported");

    // R3: unclocked writes and idle cycles interleaved with every bit
    noisy = 1;
    reselect();
    readWord(6'd12, 16'h5F4E, "R3 read with low-clock writes");
    readWord(6'd10, 16'h1B0A, "R3 second read with noise");
    noisy = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule